// File: doc/BRIEF.md
# Byte Substitution Unit with Concurrent Error Detection

This block performs the AES forward byte substitution on an 8-bit value and, at the same time, checks its own result for faults. The substitution is built as logic, as a multiplicative inverse in GF(2^8) followed by the affine map. It is not an addressed table, so there is no decoder to guard. Beside the datapath, a predictor derives a small check symbol from the input byte. A comparator recomputes the same symbol from the byte the datapath actually produced. Any difference raises the error flag.

One elaboration parameter picks the code: none, one parity bit, split parity over even and odd bit positions, a complementary pair of parity bits, or a residue modulo 3 or modulo 7. A fault mask input is XORed onto the datapath output to emulate a fault. A register stage in front of the logic and a register stage behind it sample the input, the result and the flag. This makes the unit easy to drive and observe on a clocked bench.

Top module: `sbox_ced`

## Requirements
- R1: `dout` equals S(din) XOR fault_mask, where din and fault_mask are sampled at the same rising edge and S is the AES forward S-box. The result appears two rising edges after the inputs are driven, and `err` for the same sample appears in the same cycle.
- R2: With the scheme set to none, `err` stays 0 for every input and every mask.
- R3: With fault_mask zero, `err` is 0 for all 256 input values under every scheme.
- R4: Single parity: the check symbol is the XOR of all 8 output bits. `err` is 1 exactly when the mask has odd weight, so a mask of 0x03 goes unseen.
- R5: Split parity: symbol bit 0 is the parity of output bits 0, 2, 4 and 6, and symbol bit 1 is the parity of bits 1, 3, 5 and 7. `err` is 1 when either group of mask bits has odd weight, so 0x03 is caught and 0x05 is not.
- R6: Complementary parity: both the even-parity bit and the odd-parity bit of the output are predicted and recomputed. `err` is 1 on a mismatch in either bit.
- R7: Residue: the symbol is the output value modulo RES_MOD (3 or 7). `err` is 1 exactly when (S XOR mask) mod RES_MOD differs from S mod RES_MOD.
- R8: Under every checking scheme, each of the eight single-bit masks raises `err` for every input.
- R9: While rst_n is low, `dout` is 0x00 and `err` is 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8 | Byte to substitute |
| fault_mask | input | 8 | Bits XORed onto the datapath output to emulate a fault |
| dout | output | 8 | Registered substituted byte, including any injected fault |
| err | output | 1 | Registered mismatch between predicted and recomputed check symbols |

## Verification
The hard case to reach is a fault the chosen code cannot see, since the functional datapath never produces one on its own. The fault mask port is how the stimulus gets there: the bench sweeps every single-bit mask, which each code must catch, and also applies even-weight and same-group two-bit masks, which parity codes miss. Six copies of the unit, one per scheme, take the same stimulus. For each scheme, the bench predicts from the AES table, built by its own generator loop, whether that mask changes the check symbol.

// File: rtl/sbox_ced_pkg.sv
package sbox_ced_pkg;

  localparam int BYTE_W = 8;
  localparam int SYM_W  = 3;
  localparam int INV_STEPS = 6;

  typedef enum logic [2:0] {
    CED_NONE = 3'd0,
    CED_PAR1 = 3'd1,
    CED_PAR2 = 3'd2,
    CED_CPAR = 3'd3,
    CED_RES  = 3'd4
  } ced_scheme_e;

  // Multiply in GF(2^8) modulo x^8 + x^4 + x^3 + x + 1.
  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // Affine map applied after inversion.
  function automatic logic [BYTE_W-1:0] aes_affine(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    r = b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
    return r ^ 8'h63;
  endfunction

  // x^254 through the chain x^(2^k - 1); zero maps to zero.
  function automatic logic [BYTE_W-1:0] aes_sbox(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] t;
    t = x;
    for (int k = 0; k < INV_STEPS; k++) t = gf_mul(gf_mul(t, t), x);
    return aes_affine(gf_mul(t, t));
  endfunction

  function automatic logic parity_even_idx(input logic [BYTE_W-1:0] b);
    return b[0] ^ b[2] ^ b[4] ^ b[6];
  endfunction

  function automatic logic parity_odd_idx(input logic [BYTE_W-1:0] b);
    return b[1] ^ b[3] ^ b[5] ^ b[7];
  endfunction

  // Check symbol of a byte under a scheme; residue modulus passed in.
  function automatic logic [SYM_W-1:0] ced_symbol(input logic [BYTE_W-1:0] b,
                                                  input ced_scheme_e      s,
                                                  input logic [BYTE_W-1:0] m);
    logic [SYM_W-1:0] sym;
    logic [BYTE_W-1:0] rem;
    sym = '0;
    rem = '0;
    case (s)
      CED_PAR1: sym[0] = ^b;
      CED_PAR2: sym[1:0] = {parity_odd_idx(b), parity_even_idx(b)};
      CED_CPAR: sym[1:0] = {~(^b), ^b};
      CED_RES: begin
        rem = b % m;
        sym = rem[SYM_W-1:0];
      end
      default: sym = '0;
    endcase
    return sym;
  endfunction

endpackage

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_ced_pkg::*;
(
  input  logic [BYTE_W-1:0] x,
  input  logic [BYTE_W-1:0] fault_mask,
  output logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] y
);

  localparam int CHAIN_LEN = INV_STEPS + 1;

  logic [BYTE_W-1:0] chain [CHAIN_LEN];
  logic [BYTE_W-1:0] inv;

  assign chain[0] = x;

  // Each stage squares and multiplies by x: x^3, x^7, ... x^127.
  for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_inv_stage
    logic [BYTE_W-1:0] sq;
    assign sq       = gf_mul(chain[g-1], chain[g-1]);
    assign chain[g] = gf_mul(sq, x);
  end

  assign inv = gf_mul(chain[CHAIN_LEN-1], chain[CHAIN_LEN-1]);
  assign raw = aes_affine(inv);
  assign y   = raw ^ fault_mask;

endmodule

// File: rtl/ced_predict.sv
module ced_predict
  import sbox_ced_pkg::*;
#(
  parameter ced_scheme_e SCHEME  = CED_PAR1,
  parameter int          RES_MOD = 7
) (
  input  logic [BYTE_W-1:0] x,
  output logic [SYM_W-1:0]  pred_sym
);

  localparam logic [BYTE_W-1:0] MOD_V = BYTE_W'(RES_MOD);

  // Kept as its own hierarchy: the flow must preserve it so the redundant
  // path is not shared with the datapath.
  if (SCHEME == CED_NONE) begin : g_none
    assign pred_sym = '0;
  end else begin : g_pred
    logic [BYTE_W-1:0] shadow;
    assign shadow   = aes_sbox(x);
    assign pred_sym = ced_symbol(shadow, SCHEME, MOD_V);
  end

endmodule

// File: rtl/ced_compare.sv
module ced_compare
  import sbox_ced_pkg::*;
#(
  parameter ced_scheme_e SCHEME  = CED_PAR1,
  parameter int          RES_MOD = 7
) (
  input  logic [BYTE_W-1:0] y,
  input  logic [SYM_W-1:0]  pred_sym,
  output logic [SYM_W-1:0]  actual_sym,
  output logic              mismatch
);

  localparam logic [BYTE_W-1:0] MOD_V = BYTE_W'(RES_MOD);

  if (SCHEME == CED_NONE) begin : g_none
    assign actual_sym = '0;
    assign mismatch   = 1'b0;
  end else begin : g_cmp
    assign actual_sym = ced_symbol(y, SCHEME, MOD_V);
    assign mismatch   = |(actual_sym ^ pred_sym);
  end

endmodule

// File: rtl/sbox_ced.sv
module sbox_ced
  import sbox_ced_pkg::*;
#(
  parameter ced_scheme_e SCHEME  = CED_PAR1,
  parameter int          RES_MOD = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  din,
  input  logic [7:0]  fault_mask,
  output logic [7:0]  dout,
  output logic        err
);

  logic [BYTE_W-1:0] in_q;
  logic [BYTE_W-1:0] mask_q;
  logic [BYTE_W-1:0] raw_w;
  logic [BYTE_W-1:0] out_w;
  logic [SYM_W-1:0]  pred_w;
  logic [SYM_W-1:0]  actual_w;
  logic              mismatch_w;
  logic [BYTE_W-1:0] dout_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      mask_q <= '0;
    end else begin
      in_q   <= din;
      mask_q <= fault_mask;
    end
  end

  sbox_datapath u_datapath (
    .x          (in_q),
    .fault_mask (mask_q),
    .raw        (raw_w),
    .y          (out_w)
  );

  ced_predict #(.SCHEME(SCHEME), .RES_MOD(RES_MOD)) u_predict (
    .x        (in_q),
    .pred_sym (pred_w)
  );

  ced_compare #(.SCHEME(SCHEME), .RES_MOD(RES_MOD)) u_compare (
    .y          (out_w),
    .pred_sym   (pred_w),
    .actual_sym (actual_w),
    .mismatch   (mismatch_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      err_q  <= 1'b0;
    end else begin
      dout_q <= out_w;
      err_q  <= mismatch_w;
    end
  end

  assign dout = dout_q;
  assign err  = err_q;

  // R1: output register carries the fault-free result plus exactly the mask.
  p_mask_applied_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dout_q ^ $past(raw_w)) == $past(mask_q)));

  // R2: no checking scheme, no flag.
  p_none_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (SCHEME == CED_NONE) |-> !err_q);

  // R3: a fault-free sample never raises the flag.
  p_clean_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !err_q);

  // R8: every single-bit fault is flagged by any checking scheme.
  p_single_caught_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((SCHEME != CED_NONE) && $onehot(mask_q)) |=> err_q);

endmodule

// File: tb/sbox_ced_test.sv
module sbox_ced_test;
  import sbox_ced_pkg::*;

  localparam int NINST = 6;

  typedef struct {
    logic [7:0] din;
    logic [7:0] mask;
    int         due;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] fault_mask = 8'h00;
  logic [7:0] d [NINST];
  logic       e [NINST];

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  item_t q[$];
  logic [7:0] ref_sbox [256];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sbox_ced #(.SCHEME(CED_NONE))              u_none (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[0]), .err(e[0]));
  sbox_ced #(.SCHEME(CED_PAR1))              uut    (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[1]), .err(e[1]));
  sbox_ced #(.SCHEME(CED_PAR2))              u_par2 (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[2]), .err(e[2]));
  sbox_ced #(.SCHEME(CED_CPAR))              u_cpar (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[3]), .err(e[3]));
  sbox_ced #(.SCHEME(CED_RES), .RES_MOD(3))  u_res3 (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[4]), .err(e[4]));
  sbox_ced #(.SCHEME(CED_RES), .RES_MOD(7))  u_res7 (.clk(clk), .rst_n(rst_n), .din(din), .fault_mask(fault_mask), .dout(d[5]), .err(e[5]));

  // Table built with the multiply-by-3 / divide-by-3 generator walk.
  function automatic void build_table();
    logic [7:0] p, qv, x;
    p = 8'h01;
    qv = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p  = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      qv = qv ^ {qv[6:0], 1'b0};
      qv = qv ^ {qv[5:0], 2'b00};
      qv = qv ^ {qv[3:0], 4'b0000};
      if (qv[7]) qv = qv ^ 8'h09;
      x = qv ^ {qv[6:0], qv[7]} ^ {qv[5:0], qv[7:6]} ^ {qv[4:0], qv[7:5]} ^ {qv[3:0], qv[7:4]};
      ref_sbox[p] = x ^ 8'h63;
    end
    ref_sbox[0] = 8'h63;
  endfunction

  function automatic int count_bits(input logic [7:0] v, input int start, input int step);
    int c = 0;
    for (int i = start; i < 8; i += step) if (v[i]) c++;
    return c;
  endfunction

  // Bench form of each code; only equality of symbols matters.
  function automatic int code_of(input int s, input logic [7:0] v);
    case (s)
      1: return count_bits(v, 0, 1) % 2;
      2: return (count_bits(v, 1, 2) % 2) * 2 + (count_bits(v, 0, 2) % 2);
      3: return (count_bits(v, 0, 1) % 2) ? 1 : 2;
      4: return int'(v) % 3;
      5: return int'(v) % 7;
      default: return 0;
    endcase
  endfunction

  function automatic string req_tag(input int s, input logic [7:0] m);
    if (s == 0)        return "R2";
    if (m == 8'h00)    return "R3";
    if ($onehot(m))    return "R8";
    case (s)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [7:0] v, input logic [7:0] m);
    item_t it;
    @(negedge clk);
    din = v;
    fault_mask = m;
    it.din = v;
    it.mask = m;
    it.due = cyc + 2;
    q.push_back(it);
  endtask

  // Monitor: pops items whose result is due and compares every instance.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        logic [7:0] t, expd;
        logic expe;
        it = q.pop_front();
        t = ref_sbox[it.din];
        expd = t ^ it.mask;
        for (int s = 0; s < NINST; s++) begin
          checks++;
          if (d[s] !== expd) begin
            errors++;
            $display("FAIL R1 inst %0d din %02h mask %02h: dout actual %02h expected %02h",
                     s, it.din, it.mask, d[s], expd);
          end
          expe = (code_of(s, t) != code_of(s, expd));
          checks++;
          if (e[s] !== expe) begin
            errors++;
            $display("FAIL %s inst %0d din %02h mask %02h: err actual %0b expected %0b",
                     req_tag(s, it.mask), s, it.din, it.mask, e[s], expe);
          end
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    build_table();
    // R9: reset holds outputs at zero despite active inputs.
    din = 8'hAA;
    fault_mask = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < NINST; s++) begin
      checks++;
      if (d[s] !== 8'h00 || e[s] !== 1'b0) begin
        errors++;
        $display("FAIL R9 inst %0d: actual dout %02h err %0b expected 00 0", s, d[s], e[s]);
      end
    end
    din = 8'h00;
    fault_mask = 8'h00;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 R3: every input without fault.
    for (int v = 0; v < 256; v++) drive(8'(v), 8'h00);
    // R8: every single-bit mask over a spread of inputs.
    for (int v = 0; v < 256; v += 7)
      for (int b = 0; b < 8; b++) drive(8'(v), 8'(1 << b));
    // R4 R5: 0x03 (missed by single parity, caught by split parity)
    // and 0x05 (missed by both parity codes).
    for (int v = 0; v < 256; v += 11) begin
      drive(8'(v), 8'h03);
      drive(8'(v), 8'h05);
    end
    // R6 R7: wider masks, including multiples of 3 and 7.
    for (int v = 0; v < 256; v += 13) begin
      drive(8'(v), 8'h07);
      drive(8'(v), 8'h15);
      drive(8'(v), 8'hFF);
      drive(8'(v), 8'h0E);
    end
    drive(8'h00, 8'h00);
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule